// File: doc/BRIEF.md
# Shared-Line Transmit Enable and Echo Check

This block drives the transmit data line of a serial transmitter that shares one line with other stations. Data bits go out on the falling edge of the serial bit clock. The line echo is read back on a separate receive-side input one full bit period later. The block compares each echo with the bit that was sent. A request-to-send output follows the data by one bit period. It is raised only for bits whose echo matched, so downstream logic sees only the bits that got onto the line intact.

The whole block runs on one fast system clock. The serial bit clock and the echo input both pass through the same synchronizer chain, so they stay aligned. A falling edge of the synchronized bit clock is the bit tick. A mode input selects one of two behaviours:

- **Shared-line mode:** delayed request-to-send plus collision checking.
- **Plain mode:** request-to-send simply follows the frame-active input, and no checking is done.

A mismatch sets a sticky collision flag. While the flag is set, transmission is halted. The flag clears only by reset or by a one-cycle clear pulse.

Top module: `cbus_tx_enable`

## Requirements
- R1: `txd` changes only in the system clock cycle that follows a bit tick, where a bit tick is a 1-to-0 change of the synchronized `sclk`. Between ticks, `txd` holds its value.
- R2: In shared-line mode (`bus_mode`=1), `rts` is updated at each tick. It goes to 1 exactly when a bit was driven at the previous tick and the echo sampled at this tick equals that bit; otherwise it goes to 0. This delays `rts` by one bit period behind `txd`.
- R3: In shared-line mode, the `cxd` value sampled at a tick is compared with the bit driven at the previous tick. A difference sets `col_flag` to 1.
- R4: While `col_flag` is 1 in shared-line mode, `txd` is held at 1 and `rts` at 0, whatever `frame_act` is. The tick on which the collision is detected already drives `txd` to 1.
- R5: `col_flag` is sticky. Once set, it stays at 1 until a one-cycle pulse on `col_clr` or a reset clears it.
- R6: At a tick with `frame_act`=0, `txd` is driven to 1 (idle). At a tick with `frame_act`=1 and no collision, `txd` takes the value of `tx_bit`.
- R7: In plain mode (`bus_mode`=0), `rts` equals `frame_act` delayed by one system clock cycle, without waiting for a tick, and a mismatching echo never sets `col_flag`.
- R8: With `rst`=1 on a clock edge, `txd` becomes 1 and both `rts` and `col_flag` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial bit clock; data moves on its falling edge |
| tx_bit | input | 1 | Next data bit to send, held across the tick |
| frame_act | input | 1 | 1 while a frame or character is being sent |
| cxd | input | 1 | Echo of the shared line, read back for collision checking |
| bus_mode | input | 1 | 1 selects shared-line behaviour, 0 selects plain request-to-send |
| col_clr | input | 1 | One-cycle pulse that clears the collision flag |
| txd | output | 1 | Registered transmit data line, idle high |
| rts | output | 1 | Registered request-to-send |
| col_flag | output | 1 | Sticky collision indication |

## Verification
The following relations are checked on every clock by assertions:

- `txd` stays stable between ticks.
- `txd` is forced high while transmission is halted.
- A detected mismatch sets the flag in the next cycle, and the flag then holds until cleared.
- In shared-line mode, `rts` rises only right after a tick and is held low while a collision is flagged.
- In plain mode, `rts` tracks `frame_act` with one cycle of delay.

Only the bench scenarios can show the rest:

- The one-bit-period offset between `txd` and `rts` over a real bit stream.
- That the echo is compared with the previous bit rather than the current one.
- That transmission resumes after a clear.
- That plain mode ignores a bad echo.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  // one bit waiting for its echo on the next tick
  typedef struct packed {
    logic bit_v;
    logic vld;
  } pend_t;

  localparam int CBUS_SYNC_DEF = 2;
endpackage

// File: rtl/cbus_sync_edge.sv
module cbus_sync_edge #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             fall_tick
);
  localparam int LAST = STAGES - 1;

  logic prev0;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], din[i]};
      end
      assign dout[i] = sr[LAST];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev0 <= 1'b0;
    else     prev0 <= dout[0];
  end

  assign fall_tick = prev0 & ~dout[0];

  // a falling edge cannot repeat on consecutive cycles
  assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
    fall_tick |=> !fall_tick);
endmodule

// File: rtl/cbus_tx_stage.sv
module cbus_tx_stage
  import cbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  tx_bit,
  input  logic  frame_act,
  input  logic  halt,
  output logic  txd,
  output pend_t pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      txd      <= 1'b1;
      pend.vld <= 1'b0;
      pend.bit_v <= 1'b1;
    end else if (tick) begin
      if (frame_act && !halt) begin
        txd        <= tx_bit;
        pend.bit_v <= tx_bit;
        pend.vld   <= 1'b1;
      end else begin
        txd      <= 1'b1;
        pend.vld <= 1'b0;
      end
    end
  end

  assert_txd_stable_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(txd));

  assert_txd_halt_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && halt) |=> txd);
endmodule

// File: rtl/cbus_echo_check.sv
module cbus_echo_check
  import cbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  bus_mode,
  input  logic  echo,
  input  pend_t pend,
  input  logic  col_clr,
  output logic  mis,
  output logic  col_flag
);
  assign mis = tick & bus_mode & pend.vld & (echo != pend.bit_v);

  always_ff @(posedge clk) begin
    if (rst)          col_flag <= 1'b0;
    else if (mis)     col_flag <= 1'b1;
    else if (col_clr) col_flag <= 1'b0;
  end

  assert_mis_sets_R3: assert property (@(posedge clk) disable iff (rst)
    mis |=> col_flag);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (col_flag && !col_clr) |=> col_flag);
endmodule

// File: rtl/cbus_tx_enable.sv
module cbus_tx_enable
  import cbus_pkg::*;
#(
  parameter int SYNC_STAGES = CBUS_SYNC_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic tx_bit,
  input  logic frame_act,
  input  logic cxd,
  input  logic bus_mode,
  input  logic col_clr,
  output logic txd,
  output logic rts,
  output logic col_flag
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] sync_out;
  logic              tick;
  logic              mis;
  logic              halt;
  pend_t             pend;

  cbus_sync_edge #(.STAGES(SYNC_STAGES), .WIDTH(SYNC_W)) u_sync (
    .clk(clk), .rst(rst), .din({cxd, sclk}),
    .dout(sync_out), .fall_tick(tick)
  );

  assign halt = (col_flag & bus_mode) | mis;

  cbus_tx_stage u_tx (
    .clk(clk), .rst(rst), .tick(tick), .tx_bit(tx_bit),
    .frame_act(frame_act), .halt(halt), .txd(txd), .pend(pend)
  );

  cbus_echo_check u_chk (
    .clk(clk), .rst(rst), .tick(tick), .bus_mode(bus_mode),
    .echo(sync_out[1]), .pend(pend), .col_clr(col_clr),
    .mis(mis), .col_flag(col_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)           rts <= 1'b0;
    else if (!bus_mode) rts <= frame_act;
    else if (col_flag)  rts <= 1'b0;
    else if (tick)      rts <= pend.vld & ~mis;
  end

  assert_rts_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_mode && $past(bus_mode) && $rose(rts)) |-> $past(tick));

  assert_rts_low_col_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_mode && $past(bus_mode) && $past(col_flag)) |-> !rts);

  assert_plain_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (!bus_mode && !$past(bus_mode) && !$past(rst)) |-> (rts == $past(frame_act)));
endmodule

// File: tb/cbus_tx_enable_test.sv
module cbus_tx_enable_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1, tx_bit = 1'b1, frame_act = 1'b0, cxd = 1'b1;
  logic bus_mode = 1'b1, col_clr = 1'b0;
  logic txd, rts, col_flag;
  int checks = 0, errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  cbus_tx_enable uut (
    .clk(clk), .rst(rst), .sclk(sclk), .tx_bit(tx_bit),
    .frame_act(frame_act), .cxd(cxd), .bus_mode(bus_mode),
    .col_clr(col_clr), .txd(txd), .rts(rts), .col_flag(col_flag)
  );

  // {tx_bit, frame_act, cxd, exp_txd, exp_rts, exp_col}
  localparam logic [5:0] VEC [9] = '{
    6'b011000, 6'b110110, 6'b111110, 6'b011010, 6'b100110,
    6'b001100, 6'b111100, 6'b010101, 6'b011101
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one bit period: drive inputs, falling sclk edge, rising edge, sample
  task automatic step(input logic tb, input logic fa, input logic cx);
    @(negedge clk);
    tx_bit = tb; frame_act = fa; cxd = cx;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (8) @(negedge clk);
    sclk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R8 reset txd", txd, 1'b1);
    chk("R8 reset rts", rts, 1'b0);
    chk("R8 reset col", col_flag, 1'b0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // vector walk: R2 R3 R4 R6 in shared-line mode
    for (int i = 0; i < 9; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3]);
      chk($sformatf("R6 R1 vec%0d txd", i), txd, VEC[i][2]);
      chk($sformatf("R2 vec%0d rts", i), rts, VEC[i][1]);
      chk($sformatf("R3 R4 vec%0d col", i), col_flag, VEC[i][0]);
    end

    // R5: clear pulse
    @(negedge clk); col_clr = 1'b1;
    @(negedge clk); col_clr = 1'b0;
    @(negedge clk);
    chk("R5 cleared", col_flag, 1'b0);
    chk("R4 rts after clear", rts, 1'b0);

    // resume after clear
    step(1'b0, 1'b1, 1'b1);
    chk("R6 resume txd", txd, 1'b0);
    chk("R2 first bit rts", rts, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    chk("R6 second txd", txd, 1'b1);
    chk("R2 echo match rts", rts, 1'b1);

    // R7 plain mode: bad echo ignored, rts follows frame_act
    @(negedge clk); bus_mode = 1'b0;
    step(1'b0, 1'b1, 1'b0);
    chk("R7 plain col", col_flag, 1'b0);
    chk("R7 plain txd", txd, 1'b0);
    chk("R7 plain rts", rts, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    chk("R7 plain mismatch col", col_flag, 1'b0);
    @(negedge clk); frame_act = 1'b0;
    @(negedge clk);
    chk("R7 rts drops", rts, 1'b0);
    chk("R1 txd held between ticks", txd, 1'b0);

    // R8 reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 rerst txd", txd, 1'b1);
    chk("R8 rerst rts", rts, 1'b0);
    chk("R8 rerst col", col_flag, 1'b0);
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule